// File: doc/BRIEF.md
# Hierarchical Row and Block Word Line Decoder

This block turns a row address and a column address into the enable lines of a memory array whose rows are cut into column blocks of equal width. For each access it fires one global row line, one block select line and the single local word line where the two meet. Only the cells of that block would then drive their bit-line pairs. It also produces a one-hot column select inside the active block. Storage cells, sensing and analog pulse timing lie outside the block; the array is seen only through these enables.

The number of cells per block is a parameter taking 2, 4, 8 or 16. Two structures are built depending on it. For 4 and 16 cells the block select lines gate the final 2-to-4 stage of the column decoder. For 2 and 8 cells the column lines are decoded in full first, and each block select is the OR of its group of lines, which is the NOR-based merge in active-high form. All outputs are registered. An access strobe seen in one cycle yields its lines in the next cycle only.

Top module: `dwl_decoder`

## Requirements
- R1: One cycle after a clock edge that samples `access_i` high, `grow_o` has exactly bit `row_i` set.
- R2: One cycle after a sampled access, `bsel_o` has exactly bit `col_i >> log2(CELLS_PER_BLK)` set, so the upper column bits pick the block.
- R3: One cycle after a sampled access, the only bit set in `lwl_o` is index `row*BLOCKS + block`, and a local line is set only where both its global row line and its block select are set.
- R4: One cycle after a sampled access, `csel_o` has exactly bit `col_i mod CELLS_PER_BLK` set, so the lower column bits pick the cell within the block.
- R5: One cycle after a clock edge that samples `access_i` low, `grow_o`, `bsel_o`, `lwl_o` and `csel_o` are all zero, whatever the addresses are.
- R6: `CELLS_PER_BLK` takes 2, 4, 8 and 16. The 4 and 16 settings use block-enabled 2-to-4 final stages, the 2 and 8 settings use an OR merge of full column decode lines, and all four follow R1 to R4.
- R7: While `rst_n` is low all outputs are zero, even with `access_i` high.
- R8: Each sampled access produces exactly one local word line, held for exactly one cycle. Back-to-back accesses produce consecutive, independent lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| access_i | input | 1 | Access strobe for this cycle |
| row_i | input | ROW_AW | Row address |
| col_i | input | COL_AW | Column address; upper bits block, lower bits cell |
| grow_o | output | 2**ROW_AW | One-hot global row lines |
| bsel_o | output | 2**(COL_AW-log2(CELLS_PER_BLK)) | One-hot block select lines |
| lwl_o | output | ROWS*BLOCKS | Local word lines, index row*BLOCKS+block |
| csel_o | output | CELLS_PER_BLK | One-hot column select within the block |

## Verification
On every cycle the assertions check the cycle-delayed relation between a sampled access and its row, block and column lines. They also check that a quiet strobe clears everything and that at most one local word line is active. Only the bench shows that each of the four cells-per-block structures decodes every address of a small array correctly. It drives all row and column pairs back to back and compares against positions computed arithmetically. The bench also covers reset with a live strobe, and single pulses whose lines must vanish the next cycle.

// File: rtl/dwl_pkg.sv
package dwl_pkg;

   typedef enum logic {
      DWL_STAGED = 1'b0,
      DWL_MERGED = 1'b1
   } dwl_variant_e;

   function automatic bit dwl_cpb_legal(input int cpb);
      return (cpb == 2) || (cpb == 4) || (cpb == 8) || (cpb == 16);
   endfunction

   function automatic dwl_variant_e dwl_pick(input int cpb);
      return ((cpb == 4) || (cpb == 16)) ? DWL_STAGED : DWL_MERGED;
   endfunction

endpackage

// File: rtl/dwl_onehot_dec.sv
module dwl_onehot_dec #(
   parameter int AW = 3,
   localparam int NOUT = 1 << AW
) (
   input  logic            en_i,
   input  logic [AW-1:0]   bin_i,
   output logic [NOUT-1:0] hot_o
);
   always_comb begin
      hot_o = '0;
      if (en_i) hot_o[bin_i] = 1'b1;
   end
endmodule

// File: rtl/dwl_col_path.sv
module dwl_col_path
   import dwl_pkg::*;
#(
   parameter int COL_AW        = 5,
   parameter int CELLS_PER_BLK = 4,
   localparam int CPB_AW = $clog2(CELLS_PER_BLK),
   localparam int BLK_AW = COL_AW - CPB_AW,
   localparam int BLOCKS = 1 << BLK_AW,
   localparam int COLS   = 1 << COL_AW
) (
   input  logic                     en_i,
   input  logic [COL_AW-1:0]        col_i,
   output logic [BLOCKS-1:0]        bsel_o,
   output logic [CELLS_PER_BLK-1:0] csel_o
);
   localparam dwl_variant_e VARIANT = dwl_pick(CELLS_PER_BLK);

   logic [COLS-1:0] coldec;

   generate
      if (VARIANT == DWL_STAGED) begin : g_staged
         // block select first, then it enables every final 2-to-4 stage
         localparam int PRE_AW = CPB_AW - 2;
         localparam int NPRE   = 1 << PRE_AW;
         logic [3:0]      fin;
         logic [NPRE-1:0] pre;

         dwl_onehot_dec #(.AW(BLK_AW)) u_blk (
            .en_i (en_i),
            .bin_i(col_i[COL_AW-1:CPB_AW]),
            .hot_o(bsel_o)
         );
         dwl_onehot_dec #(.AW(2)) u_fin (
            .en_i (1'b1),
            .bin_i(col_i[1:0]),
            .hot_o(fin)
         );
         if (PRE_AW > 0) begin : g_pre
            dwl_onehot_dec #(.AW(PRE_AW)) u_pre (
               .en_i (1'b1),
               .bin_i(col_i[CPB_AW-1:2]),
               .hot_o(pre)
            );
         end else begin : g_nopre
            assign pre = 1'b1;
         end
         for (genvar b = 0; b < BLOCKS; b++) begin : g_b
            for (genvar p = 0; p < NPRE; p++) begin : g_p
               for (genvar q = 0; q < 4; q++) begin : g_q
                  assign coldec[b*CELLS_PER_BLK + p*4 + q] = bsel_o[b] & pre[p] & fin[q];
               end
            end
         end
      end else begin : g_merged
         // full column decode first, block select is the OR of its group
         dwl_onehot_dec #(.AW(COL_AW)) u_col (
            .en_i (en_i),
            .bin_i(col_i),
            .hot_o(coldec)
         );
         for (genvar b = 0; b < BLOCKS; b++) begin : g_b
            assign bsel_o[b] = |coldec[b*CELLS_PER_BLK +: CELLS_PER_BLK];
         end
      end
   endgenerate

   // in-block column select merges the same offset of every block
   always_comb begin
      csel_o = '0;
      for (int b = 0; b < BLOCKS; b++) begin
         csel_o = csel_o | coldec[b*CELLS_PER_BLK +: CELLS_PER_BLK];
      end
   end
endmodule

// File: rtl/dwl_local_gate.sv
module dwl_local_gate #(
   parameter int ROWS   = 16,
   parameter int BLOCKS = 8,
   localparam int NLWL = ROWS * BLOCKS
) (
   input  logic [ROWS-1:0]   grow_i,
   input  logic [BLOCKS-1:0] bsel_i,
   output logic [NLWL-1:0]   lwl_o
);
   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_r
         for (genvar b = 0; b < BLOCKS; b++) begin : g_b
            assign lwl_o[r*BLOCKS + b] = grow_i[r] & bsel_i[b];
         end
      end
   endgenerate
endmodule

// File: rtl/dwl_decoder.sv
module dwl_decoder
   import dwl_pkg::*;
#(
   parameter int ROW_AW        = 4,
   parameter int COL_AW        = 5,
   parameter int CELLS_PER_BLK = 4,
   localparam int CPB_AW = $clog2(CELLS_PER_BLK),
   localparam int BLK_AW = COL_AW - CPB_AW,
   localparam int ROWS   = 1 << ROW_AW,
   localparam int BLOCKS = 1 << BLK_AW,
   localparam int NLWL   = ROWS * BLOCKS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     access_i,
   input  logic [ROW_AW-1:0]        row_i,
   input  logic [COL_AW-1:0]        col_i,
   output logic [ROWS-1:0]          grow_o,
   output logic [BLOCKS-1:0]        bsel_o,
   output logic [NLWL-1:0]          lwl_o,
   output logic [CELLS_PER_BLK-1:0] csel_o
);
   initial begin : cfg_chk
      if (!dwl_cpb_legal(CELLS_PER_BLK))
         $error("CELLS_PER_BLK must be 2, 4, 8 or 16");
      if (BLK_AW < 1)
         $error("COL_AW must leave at least one block address bit");
      if (ROW_AW < 1)
         $error("ROW_AW must be at least 1");
   end

   logic [ROWS-1:0]          grow_c;
   logic [BLOCKS-1:0]        bsel_c;
   logic [NLWL-1:0]          lwl_c;
   logic [CELLS_PER_BLK-1:0] csel_c;

   dwl_onehot_dec #(.AW(ROW_AW)) u_row (
      .en_i (access_i),
      .bin_i(row_i),
      .hot_o(grow_c)
   );

   dwl_col_path #(.COL_AW(COL_AW), .CELLS_PER_BLK(CELLS_PER_BLK)) u_col (
      .en_i  (access_i),
      .col_i (col_i),
      .bsel_o(bsel_c),
      .csel_o(csel_c)
   );

   dwl_local_gate #(.ROWS(ROWS), .BLOCKS(BLOCKS)) u_gate (
      .grow_i(grow_c),
      .bsel_i(bsel_c),
      .lwl_o (lwl_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grow_o <= '0;
         bsel_o <= '0;
         lwl_o  <= '0;
         csel_o <= '0;
      end else begin
         grow_o <= grow_c;
         bsel_o <= bsel_c;
         lwl_o  <= lwl_c;
         csel_o <= csel_c;
      end
   end

   // R1
   grow_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      access_i |=> (grow_o == (ROWS'(1) << $past(row_i))));
   // R2
   bsel_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      access_i |=> (bsel_o == (BLOCKS'(1) << ($past(col_i) >> CPB_AW))));
   // R4
   csel_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      access_i |=> ($onehot0(csel_o) && ($countones(csel_o) == 1)));
   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !access_i |=> ((grow_o == '0) && (bsel_o == '0) && (lwl_o == '0) && (csel_o == '0)));
   // R8
   one_lwl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      access_i |=> ($countones(lwl_o) == 1));
   // R3
   lwl_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lwl_o));
   // R3
   lwl_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lwl_o != '0) |-> ($countones(grow_o) == 1 && $countones(bsel_o) == 1));
endmodule

// File: tb/dwl_decoder_tb_top.sv
module dwl_decoder_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RAW  = 3;
   localparam int CAW  = 5;
   localparam int NR   = 1 << RAW;
   localparam int NC   = 1 << CAW;
   localparam int WDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic access = 1'b0;
   logic [RAW-1:0] row = '0;
   logic [CAW-1:0] col = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // cells per block 4 (main), 2, 8, 16
   logic [NR-1:0] g4, g2, g8, g16;
   logic [NC/4-1:0] b4;  logic [NC/2-1:0] b2;
   logic [NC/8-1:0] b8;  logic [NC/16-1:0] b16;
   logic [NR*NC/4-1:0] l4;  logic [NR*NC/2-1:0] l2;
   logic [NR*NC/8-1:0] l8;  logic [NR*NC/16-1:0] l16;
   logic [3:0] c4; logic [1:0] c2; logic [7:0] c8; logic [15:0] c16;

   dwl_decoder #(.ROW_AW(RAW), .COL_AW(CAW), .CELLS_PER_BLK(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .access_i(access), .row_i(row), .col_i(col),
      .grow_o(g4), .bsel_o(b4), .lwl_o(l4), .csel_o(c4));
   dwl_decoder #(.ROW_AW(RAW), .COL_AW(CAW), .CELLS_PER_BLK(2)) dut2_i (
      .clk(clk), .rst_n(rst_n), .access_i(access), .row_i(row), .col_i(col),
      .grow_o(g2), .bsel_o(b2), .lwl_o(l2), .csel_o(c2));
   dwl_decoder #(.ROW_AW(RAW), .COL_AW(CAW), .CELLS_PER_BLK(8)) dut8_i (
      .clk(clk), .rst_n(rst_n), .access_i(access), .row_i(row), .col_i(col),
      .grow_o(g8), .bsel_o(b8), .lwl_o(l8), .csel_o(c8));
   dwl_decoder #(.ROW_AW(RAW), .COL_AW(CAW), .CELLS_PER_BLK(16)) dut16_i (
      .clk(clk), .rst_n(rst_n), .access_i(access), .row_i(row), .col_i(col),
      .grow_o(g16), .bsel_o(b16), .lwl_o(l16), .csel_o(c16));

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic cmp(input string req, input int cpb, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         if (n_bad < 20)
            $display("FAIL %s cpb=%0d %s act=%h exp=%h", req, cpb, what, act, exp);
      end
   endtask

   task automatic unit(input int cpb, input bit s, input int r, input int c,
                       input logic [255:0] g, input logic [255:0] b,
                       input logic [255:0] l, input logic [255:0] cs);
      logic [255:0] eg, eb, el, ec;
      int nblk, blk;
      nblk = NC / cpb;
      blk  = c / cpb;
      eg = '0; eb = '0; el = '0; ec = '0;
      if (s) begin
         eg[r] = 1'b1;
         eb[blk] = 1'b1;
         el[r*nblk + blk] = 1'b1;
         ec[c % cpb] = 1'b1;
      end
      // R6: every variant held to R1..R4 / R5
      cmp(s ? "R1" : "R5", cpb, "grow", g, eg);
      cmp(s ? "R2" : "R5", cpb, "bsel", b, eb);
      cmp(s ? "R3_R8" : "R5", cpb, "lwl", l, el);
      cmp(s ? "R4" : "R5", cpb, "csel", cs, ec);
   endtask

   task automatic check_all(input bit s, input int r, input int c);
      unit(4,  s, r, c, 256'(g4),  256'(b4),  256'(l4),  256'(c4));
      unit(2,  s, r, c, 256'(g2),  256'(b2),  256'(l2),  256'(c2));
      unit(8,  s, r, c, 256'(g8),  256'(b8),  256'(l8),  256'(c8));
      unit(16, s, r, c, 256'(g16), 256'(b16), 256'(l16), 256'(c16));
   endtask

   // drive at a falling edge, check at the next falling edge
   task automatic step(input bit s, input int r, input int c);
      access = s;
      row = RAW'(r);
      col = CAW'(c);
      @(negedge clk);
      check_all(s, r, c);
   endtask

   initial begin : watchdog
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      // R7: reset held with a live strobe
      @(negedge clk);
      access = 1'b1; row = 3'd5; col = 5'd9;
      repeat (3) @(negedge clk);
      check_all(1'b0, 0, 0);
      access = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // R1..R4, R8: every address, back-to-back accesses
      for (int r = 0; r < NR; r++) begin
         for (int c = 0; c < NC; c++) begin
            step(1'b1, r, c);
         end
      end
      // R5: quiet strobe with changing addresses
      for (int k = 0; k < 16; k++) begin
         step(1'b0, (k * 3) % NR, (k * 7) % NC);
      end
      // R8: isolated pulses last one cycle
      for (int k = 0; k < 8; k++) begin
         step(1'b1, k, NC - 1 - k * 3);
         step(1'b0, k, NC - 1 - k * 3);
      end
      // R7: reset mid-stream clears outputs
      step(1'b1, 7, 31);
      rst_n = 1'b0;
      access = 1'b1;
      @(negedge clk);
      check_all(1'b0, 0, 0);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule